// File: doc/BRIEF.md
# Toy Quadcopter Frame Scheduler

This block produces the control traffic of a four-channel toy drone link that hops over four radio channels. At fixed points in time it builds a 16-byte packet. During pairing this is a bind packet, which carries the device identity and the hop list. After pairing it is a flight packet, which carries four 10-bit stick positions, three trims and two switches. The block streams each packet byte by byte to a downstream encoder. It also drives the RF channel number, a transmit-address select and a one-cycle send strobe that tells the radio when to transmit.

Time is counted in microseconds, using a tick from a prescaler of the system clock. Each hop period sends the same packet twice on the same channel, with a short gap between the two sends and a long gap before the next period. The bind phase lasts a fixed number of periods on a fixed channel. Once the bind phase ends, the address select flips to the device identity, and the channel steps through the four hop entries. For the first flight packets the throttle is held at mid-scale.

The packet leaves on a valid/ready byte stream. A byte moves only in a cycle where both `pkt_valid_o` and `pkt_ready_i` are high. While `pkt_ready_i` is low, the offered byte and the last flag stay unchanged. The downstream side is expected to drain all 16 bytes within one short gap. If a new packet is built while bytes are still waiting, the waiting bytes are dropped. A slow consumer never delays the send strobe or the channel timing.

Top module: `quad_frame_sched`

## Requirements
- R1: In every packet, byte 0 is 0x0F, byte 1 is 0xA4 for bind and 0xA6 for flight, and byte 15 is 0x00. Byte 14 equals the sum modulo 256 of bytes 0 to 13. Every byte with no assigned content is 0x00.
- R2: A bind packet carries bit-reversed identity bytes in bytes 2 to 5, taking identity bytes 2, 3, 0 and 1 in that order. Identity byte k is `dev_id_i[8k+7:8k]`. Bytes 6 to 9 hold effective hop entries 0 to 3, each minus 2.
- R3: A flight packet has byte 2 = 0xF7 and byte 3 = 0x00. Byte 4 is 0x20 when take-off is set, OR 0x04 when emergency stop is set. Roll goes in bytes 5 and 6, pitch in bytes 7 and 8, throttle in bytes 9 and 10, and yaw in bytes 11 and 12. For each axis the first byte is (trim AND 0xFC) OR value[9:8] and the second byte is value[7:0]. Throttle uses a fixed trim of 0x7C.
- R4: The first HOLD_PKTS+1 flight packets carry throttle 0x200. Every later flight packet carries the live throttle input.
- R5: Each hop period lasts PERIOD_US microseconds, and one microsecond is CLK_PER_US clocks. `send_o` pulses for one cycle at the start of each period and again GAP_US microseconds later.
- R6: During the first BIND_PERIODS periods, the channel is 0x2D and `addr_sel_o` is 0. The packet built after the second send of the last bind period is a flight packet. From the next period on, `addr_sel_o` is 1 and it never returns to 0.
- R7: After the bind phase, period p uses effective hop entry p mod 4. The effective entry is the table entry plus 1 if the entry equals 0x2D, and the entry itself otherwise. Hop entry k is `hop_tbl_i[8k+7:8k]`. The channel changes only in the cycle after a second-send strobe, never while `send_o` is high.
- R8: Packet bytes leave in order 0 to 15. `pkt_last_o` is high with byte 15. While valid is high and ready is low, the data and last outputs are held.
- R9: A packet is built from the inputs one cycle after reset is released, and one cycle after every second-send strobe. Building discards any unaccepted bytes and restarts the stream at byte 0, even if a handshake happens in that same cycle.
- R10: Right after reset, `pkt_valid_o` and `send_o` are low, `rf_chan_o` is 0x2D and `addr_sel_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| roll_i | input | 10 | Roll stick value |
| pitch_i | input | 10 | Pitch stick value |
| thr_i | input | 10 | Throttle stick value |
| yaw_i | input | 10 | Yaw stick value |
| roll_trim_i | input | 8 | Roll trim, top six bits used |
| pitch_trim_i | input | 8 | Pitch trim, top six bits used |
| yaw_trim_i | input | 8 | Yaw trim, top six bits used |
| takeoff_i | input | 1 | Take-off / land switch |
| estop_i | input | 1 | Emergency stop switch |
| dev_id_i | input | 32 | Four identity bytes, byte k at bits 8k+7:8k |
| hop_tbl_i | input | 32 | Four hop channels, entry k at bits 8k+7:8k |
| pkt_data_o | output | 8 | Stream byte |
| pkt_valid_o | output | 1 | Stream byte valid |
| pkt_ready_i | input | 1 | Downstream accepts the byte |
| pkt_last_o | output | 1 | Marks byte 15 of the packet |
| rf_chan_o | output | 8 | RF channel for the current period |
| addr_sel_o | output | 1 | 0 = fixed bind address, 1 = device identity |
| send_o | output | 1 | One-cycle transmit strobe |

## Verification
Two functions can land on the same clock edge. One is the packet rebuild that follows a second send. The other is the downstream accepting a byte of a packet it has only partly drained. The bench accepts part of a packet and then holds ready low until the next second-send strobe. It raises ready in the very cycle before the rebuild edge, so a stale byte is handshaken on that edge. The result is judged correct only if the next bytes seen are the complete new packet from byte 0, with the inputs changed in between, a correct checksum and the last flag on byte 15.

// File: rtl/qfs_pkg.sv
`timescale 1ns/1ps
package qfs_pkg;
  localparam int PKT_BYTES = 16;
  localparam int HOPS      = 4;
  localparam int SUM_BYTES = 14;
  localparam int SUM_POS   = 14;

  localparam logic [7:0] BIND_CHAN = 8'h2D;
  localparam logic [7:0] HDR_LEN   = 8'h0F;
  localparam logic [7:0] KIND_BIND = 8'hA4;
  localparam logic [7:0] KIND_FLY  = 8'hA6;
  localparam logic [7:0] RATE_HI   = 8'hF7;
  localparam logic [7:0] SW_TAKEOFF = 8'h20;
  localparam logic [7:0] SW_ESTOP   = 8'h04;
  localparam logic [9:0] THR_MID   = 10'h200;
  localparam logic [5:0] THR_TRIM  = 6'h1F;

  typedef logic [PKT_BYTES-1:0][7:0] pkt_t;
  typedef logic [HOPS-1:0][7:0]      hops_t;

  function automatic logic [7:0] rev8(input logic [7:0] b);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = b[7-i];
    return r;
  endfunction

  function automatic logic [7:0] axis_hi(input logic [7:0] trim, input logic [9:0] v);
    return {trim[7:2], v[9:8]};
  endfunction
endpackage

// File: rtl/qfs_tick.sv
`timescale 1ns/1ps
module qfs_tick #(
  parameter int DIV = 200
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] C_LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = (cnt_q == C_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/qfs_build.sv
`timescale 1ns/1ps
module qfs_build
  import qfs_pkg::*;
(
  input  logic       bind_i,
  input  logic       hold_i,
  input  logic [9:0] roll_i,
  input  logic [9:0] pitch_i,
  input  logic [9:0] thr_i,
  input  logic [9:0] yaw_i,
  input  logic [7:0] roll_trim_i,
  input  logic [7:0] pitch_trim_i,
  input  logic [7:0] yaw_trim_i,
  input  logic       takeoff_i,
  input  logic       estop_i,
  input  logic [31:0] dev_id_i,
  input  hops_t      hop_i,
  output pkt_t       pkt_o
);
  logic [9:0] thr_v;
  logic [7:0] sum;
  pkt_t       body;

  assign thr_v = hold_i ? THR_MID : thr_i;

  always_comb begin
    body    = '0;
    body[0] = HDR_LEN;
    if (bind_i) begin
      body[1] = KIND_BIND;
      body[2] = rev8(dev_id_i[23:16]);
      body[3] = rev8(dev_id_i[31:24]);
      body[4] = rev8(dev_id_i[7:0]);
      body[5] = rev8(dev_id_i[15:8]);
      for (int k = 0; k < HOPS; k++) body[6+k] = hop_i[k] - 8'd2;
    end else begin
      body[1]  = KIND_FLY;
      body[2]  = RATE_HI;
      body[4]  = (takeoff_i ? SW_TAKEOFF : 8'h00) | (estop_i ? SW_ESTOP : 8'h00);
      body[5]  = axis_hi(roll_trim_i, roll_i);
      body[6]  = roll_i[7:0];
      body[7]  = axis_hi(pitch_trim_i, pitch_i);
      body[8]  = pitch_i[7:0];
      body[9]  = {THR_TRIM, thr_v[9:8]};
      body[10] = thr_v[7:0];
      body[11] = axis_hi(yaw_trim_i, yaw_i);
      body[12] = yaw_i[7:0];
    end
  end

  always_comb begin
    sum = '0;
    for (int i = 0; i < SUM_BYTES; i++) sum = sum + body[i];
  end

  always_comb begin
    pkt_o          = body;
    pkt_o[SUM_POS] = sum;
  end
endmodule

// File: rtl/qfs_stream.sv
`timescale 1ns/1ps
module qfs_stream
  import qfs_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       load_i,
  input  pkt_t       pkt_i,
  output logic [7:0] data_o,
  output logic       valid_o,
  input  logic       ready_i,
  output logic       last_o
);
  localparam int IW = $clog2(PKT_BYTES);
  localparam logic [IW-1:0] I_LAST = IW'(PKT_BYTES - 1);

  pkt_t          buf_q;
  logic [IW-1:0] idx_q;
  logic          valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q   <= '0;
      idx_q   <= '0;
      valid_q <= 1'b0;
    end else if (load_i) begin
      buf_q   <= pkt_i;
      idx_q   <= '0;
      valid_q <= 1'b1;
    end else if (valid_q && ready_i) begin
      if (idx_q == I_LAST) valid_q <= 1'b0;
      else                 idx_q   <= idx_q + 1'b1;
    end
  end

  assign data_o  = buf_q[idx_q];
  assign valid_o = valid_q;
  assign last_o  = valid_q && (idx_q == I_LAST);

  // R8: an offered byte waits unchanged for the consumer
  assert_hold_stall_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && !ready_i && !load_i) |=> (valid_q && $stable(data_o) && $stable(last_o)));

  // R9: a build always restarts at byte 0 with data offered
  assert_restart_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (valid_q && idx_q == '0));
endmodule

// File: rtl/qfs_seq.sv
`timescale 1ns/1ps
module qfs_seq
  import qfs_pkg::*;
#(
  parameter int GAP_US       = 1260,
  parameter int PERIOD_US    = 5200,
  parameter int BIND_PERIODS = 384,
  parameter int HOLD_PKTS    = 200
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        tick_i,
  input  logic [31:0] hop_tbl_i,
  output logic        load_o,
  output logic        bind_o,
  output logic        hold_o,
  output logic        send_o,
  output logic        addr_sel_o,
  output logic [7:0]  rf_chan_o,
  output hops_t       hop_eff_o
);
  localparam int UW = $clog2(PERIOD_US);
  localparam int BW = (BIND_PERIODS > 0) ? $clog2(BIND_PERIODS + 1) : 1;
  localparam int HW = $clog2(HOLD_PKTS + 2);
  localparam int IW = $clog2(HOPS);
  localparam logic [UW-1:0] U_LAST = UW'(PERIOD_US - 1);
  localparam logic [UW-1:0] U_GAP  = UW'(GAP_US);
  localparam logic [BW-1:0] B_INIT = BW'(BIND_PERIODS);
  localparam logic [BW-1:0] B_ONE  = BW'(1);
  localparam logic [HW-1:0] H_MAX  = HW'(HOLD_PKTS);

  genvar g;
  generate
    for (g = 0; g < HOPS; g++) begin : g_hop
      assign hop_eff_o[g] = (hop_tbl_i[8*g +: 8] == BIND_CHAN) ?
                            (BIND_CHAN + 8'd1) : hop_tbl_i[8*g +: 8];
    end
  endgenerate

  logic [UW-1:0] us_q;
  logic          send_q, post_q, init_q, asel_q;
  logic [BW-1:0] bind_q;
  logic [IW-1:0] hop_q, hop_next;
  logic [HW-1:0] hold_q;
  logic [7:0]    chan_q;
  logic          at_a, at_b, bind_next, forced;

  assign at_a      = tick_i && (us_q == '0);
  assign at_b      = tick_i && (us_q == U_GAP);
  assign load_o    = init_q || post_q;
  assign bind_next = post_q ? (bind_q > B_ONE) : (bind_q != '0);
  assign hop_next  = post_q ? (hop_q + 1'b1) : hop_q;
  assign forced    = (hold_q <= H_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      us_q   <= '0;
      send_q <= 1'b0;
      post_q <= 1'b0;
      init_q <= 1'b1;
      bind_q <= B_INIT;
      hop_q  <= '0;
      hold_q <= '0;
      chan_q <= BIND_CHAN;
      asel_q <= (BIND_PERIODS == 0);
    end else begin
      if (tick_i) us_q <= (us_q == U_LAST) ? '0 : (us_q + 1'b1);
      send_q <= at_a || at_b;
      post_q <= at_b;
      init_q <= 1'b0;
      if (load_o) begin
        if (post_q && (bind_q != '0)) bind_q <= bind_q - 1'b1;
        hop_q  <= hop_next;
        chan_q <= bind_next ? BIND_CHAN : hop_eff_o[hop_next];
        asel_q <= !bind_next;
        if (!bind_next && forced) hold_q <= hold_q + 1'b1;
      end
    end
  end

  assign bind_o     = bind_next;
  assign hold_o     = forced;
  assign send_o     = send_q;
  assign addr_sel_o = asel_q;
  assign rf_chan_o  = chan_q;

  // R5: a send strobe lasts one cycle
  assert_strobe_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    send_q |=> !send_q);

  // R7: channel held across a send strobe
  assert_chan_stable_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    send_q |-> $stable(chan_q));

  // R6: address select never reverts to the bind address
  assert_addr_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    asel_q |=> asel_q);

  // R6: bind address goes with the bind channel
  assert_bind_chan_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !asel_q |-> (chan_q == BIND_CHAN));

  // R7: a hop channel never lands on the bind channel
  assert_hop_not_bind_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (asel_q && !init_q) |-> (chan_q != BIND_CHAN));
endmodule

// File: rtl/quad_frame_sched.sv
`timescale 1ns/1ps
module quad_frame_sched
  import qfs_pkg::*;
#(
  parameter int CLK_PER_US   = 200,
  parameter int GAP_US       = 1260,
  parameter int PERIOD_US    = 5200,
  parameter int BIND_PERIODS = 384,
  parameter int HOLD_PKTS    = 200
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [9:0]  roll_i,
  input  logic [9:0]  pitch_i,
  input  logic [9:0]  thr_i,
  input  logic [9:0]  yaw_i,
  input  logic [7:0]  roll_trim_i,
  input  logic [7:0]  pitch_trim_i,
  input  logic [7:0]  yaw_trim_i,
  input  logic        takeoff_i,
  input  logic        estop_i,
  input  logic [31:0] dev_id_i,
  input  logic [31:0] hop_tbl_i,
  output logic [7:0]  pkt_data_o,
  output logic        pkt_valid_o,
  input  logic        pkt_ready_i,
  output logic        pkt_last_o,
  output logic [7:0]  rf_chan_o,
  output logic        addr_sel_o,
  output logic        send_o
);
  logic  tick, load, bind_mode, hold;
  hops_t hop_eff;
  pkt_t  pkt;

  qfs_tick #(.DIV(CLK_PER_US)) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(tick)
  );

  qfs_seq #(
    .GAP_US      (GAP_US),
    .PERIOD_US   (PERIOD_US),
    .BIND_PERIODS(BIND_PERIODS),
    .HOLD_PKTS   (HOLD_PKTS)
  ) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick),
    .hop_tbl_i (hop_tbl_i),
    .load_o    (load),
    .bind_o    (bind_mode),
    .hold_o    (hold),
    .send_o    (send_o),
    .addr_sel_o(addr_sel_o),
    .rf_chan_o (rf_chan_o),
    .hop_eff_o (hop_eff)
  );

  qfs_build u_build (
    .bind_i      (bind_mode),
    .hold_i      (hold),
    .roll_i      (roll_i),
    .pitch_i     (pitch_i),
    .thr_i       (thr_i),
    .yaw_i       (yaw_i),
    .roll_trim_i (roll_trim_i),
    .pitch_trim_i(pitch_trim_i),
    .yaw_trim_i  (yaw_trim_i),
    .takeoff_i   (takeoff_i),
    .estop_i     (estop_i),
    .dev_id_i    (dev_id_i),
    .hop_i       (hop_eff),
    .pkt_o       (pkt)
  );

  qfs_stream u_stream (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .pkt_i  (pkt),
    .data_o (pkt_data_o),
    .valid_o(pkt_valid_o),
    .ready_i(pkt_ready_i),
    .last_o (pkt_last_o)
  );
endmodule

// File: tb/tb_quad_frame_sched.sv
`timescale 1ns/1ps
module tb_quad_frame_sched;
  localparam int DIV = 2, GAP = 12, PER = 40, NBIND = 4, HOLD = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [9:0] roll = 10'h000, pitch = 10'h000, thr = 10'h000, yaw = 10'h000;
  logic [7:0] rtrim = 8'h00, ptrim = 8'h00, ytrim = 8'h00;
  logic to_sw = 1'b0, es_sw = 1'b0;
  logic [31:0] dev_id = 32'hA305_22C1;
  logic [31:0] hops   = 32'h414B_2D3C;
  logic [7:0] pkt_data;
  logic pkt_valid, pkt_ready = 1'b0, pkt_last;
  logic [7:0] rf_chan;
  logic addr_sel, send;

  int checks = 0, errors = 0, cyc = 0, scnt = 0, nb = 0;
  int s_cyc [64];
  logic [7:0] s_chan [64];
  logic s_addr [64];
  logic [7:0] exp_b [16];

  quad_frame_sched #(.CLK_PER_US(DIV), .GAP_US(GAP), .PERIOD_US(PER),
                     .BIND_PERIODS(NBIND), .HOLD_PKTS(HOLD)) dut (
    .clk_i(clk), .rst_ni(rst_n), .roll_i(roll), .pitch_i(pitch), .thr_i(thr), .yaw_i(yaw),
    .roll_trim_i(rtrim), .pitch_trim_i(ptrim), .yaw_trim_i(ytrim),
    .takeoff_i(to_sw), .estop_i(es_sw), .dev_id_i(dev_id), .hop_tbl_i(hops),
    .pkt_data_o(pkt_data), .pkt_valid_o(pkt_valid), .pkt_ready_i(pkt_ready),
    .pkt_last_o(pkt_last), .rf_chan_o(rf_chan), .addr_sel_o(addr_sel), .send_o(send));

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // strobe recorder, sampled 1 ns after the edge
  always @(posedge clk) begin
    #1;
    if (send && scnt < 63) begin
      scnt = scnt + 1;
      s_cyc[scnt]  = cyc;
      s_chan[scnt] = rf_chan;
      s_addr[scnt] = addr_sel;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] rv(input logic [7:0] b);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = b[7-i];
    return r;
  endfunction

  function automatic logic [7:0] heff(input int k);
    logic [7:0] e;
    e = hops[8*k +: 8];
    return (e == 8'h2D) ? 8'h2E : e;
  endfunction

  task automatic make_exp(input bit bnd, input bit forced);
    logic [9:0] tv;
    logic [7:0] s;
    for (int i = 0; i < 16; i++) exp_b[i] = 8'h00;
    exp_b[0] = 8'h0F;
    if (bnd) begin
      exp_b[1] = 8'hA4;
      exp_b[2] = rv(dev_id[23:16]);
      exp_b[3] = rv(dev_id[31:24]);
      exp_b[4] = rv(dev_id[7:0]);
      exp_b[5] = rv(dev_id[15:8]);
      for (int k = 0; k < 4; k++) exp_b[6+k] = heff(k) - 8'd2;
    end else begin
      tv = forced ? 10'h200 : thr;
      exp_b[1]  = 8'hA6;
      exp_b[2]  = 8'hF7;
      exp_b[4]  = (to_sw ? 8'h20 : 8'h00) | (es_sw ? 8'h04 : 8'h00);
      exp_b[5]  = {rtrim[7:2], roll[9:8]};  exp_b[6]  = roll[7:0];
      exp_b[7]  = {ptrim[7:2], pitch[9:8]}; exp_b[8]  = pitch[7:0];
      exp_b[9]  = {6'h1F, tv[9:8]};         exp_b[10] = tv[7:0];
      exp_b[11] = {ytrim[7:2], yaw[9:8]};   exp_b[12] = yaw[7:0];
    end
    s = 8'h00;
    for (int i = 0; i < 14; i++) s = s + exp_b[i];
    exp_b[14] = s;
  endtask

  function automatic string req_of(input int i, input bit bnd);
    if (i <= 1 || i >= 13) return "R1";
    if (bnd) return (i <= 9) ? "R2" : "R1";
    if (i == 9 || i == 10) return "R4";
    return "R3";
  endfunction

  // Collects one whole packet; ready is raised in the calling cycle
  task automatic grab(input bit bnd, input bit forced, input string pre);
    int n;
    make_exp(bnd, forced);
    pkt_ready = 1'b1;
    n = 0;
    while (n < 16) begin
      @(negedge clk);
      if (pkt_valid) begin
        check({pre, req_of(n, bnd), $sformatf(" byte%0d", n)}, pkt_data, exp_b[n]);
        if (n == 15) check({pre, "R8 last flag"}, pkt_last, 1'b1);
        n++;
      end
    end
    @(negedge clk);
    pkt_ready = 1'b0;
  endtask

  task automatic wait_strobes(input int n);
    while (scnt < n) @(negedge clk);
  endtask

  // Runs hop period p and collects the packet built at its end
  task automatic run_period(input int p, input string pre);
    bit bnd, forced;
    wait_strobes(2*p + 2);
    check($sformatf("R6 addr sel period %0d", p), s_addr[2*p+1], (p >= NBIND));
    check($sformatf("R7 channel A period %0d", p), s_chan[2*p+1],
          (p < NBIND) ? 8'h2D : heff(p % 4));
    check($sformatf("R7 channel B period %0d", p), s_chan[2*p+2], s_chan[2*p+1]);
    check("R5 short gap", s_cyc[2*p+2] - s_cyc[2*p+1], GAP*DIV);
    if (p > 0) check("R5 period", s_cyc[2*p+1] - s_cyc[2*p-1], PER*DIV);
    bnd    = (p + 1) < NBIND;
    forced = !bnd && (nb <= HOLD);
    if (!bnd) nb++;
    grab(bnd, forced, pre);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    check("R10 valid in reset", pkt_valid, 1'b0);
    check("R10 send in reset", send, 1'b0);
    check("R10 channel in reset", rf_chan, 8'h2D);
    check("R10 addr in reset", addr_sel, 1'b0);
  endtask

  task automatic t_first_packet;
    rst_n = 1'b1;
    grab(1'b1, 1'b0, "init ");
  endtask

  task automatic t_bind_phase;
    for (int p = 0; p < NBIND; p++) begin
      roll = 10'(37 * p + 5); pitch = 10'h3FF - 10'(p); thr = 10'h3F0; yaw = 10'h155;
      rtrim = 8'h7F; ptrim = 8'h83; ytrim = 8'hFF;
      run_period(p, "bind ");
    end
  endtask

  task automatic t_hold_phase;
    for (int p = NBIND; p < NBIND + 4; p++) begin
      to_sw = p[0]; es_sw = p[1];
      roll = 10'h2A5; pitch = 10'h15A; thr = 10'h0C3 + 10'(p); yaw = 10'h301;
      rtrim = 8'h3D; ptrim = 8'hC2; ytrim = 8'h01;
      run_period(p, "hold ");
    end
  endtask

  task automatic t_restart;
    logic [7:0] d;
    int p;
    p = NBIND + 4;
    thr = 10'h111;
    wait_strobes(2*p + 2);
    nb++;
    pkt_ready = 1'b1;
    repeat (6) @(negedge clk);
    pkt_ready = 1'b0;
    @(negedge clk);
    d = pkt_data;
    check("R8 valid during stall", pkt_valid, 1'b1);
    repeat (3) @(negedge clk);
    check("R8 data held in stall", pkt_data, d);
    check("R8 valid held in stall", pkt_valid, 1'b1);
    roll = 10'h07E; pitch = 10'h381; thr = 10'h2FF; yaw = 10'h000;
    to_sw = 1'b1; es_sw = 1'b1; ytrim = 8'h80;
    run_period(p + 1, "R9 restart ");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL R5 watchdog act=timeout exp=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_first_packet();
    t_bind_phase();
    t_hold_phase();
    t_restart();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule